// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block merges interrupt events from two cascaded groups into a single active-high interrupt line for a host controller. Each group has a status register that captures events and an enable register that selects which captured events count. The inner group also has a master enable in bit 31 of its enable register. When the inner group produces a master-gated result, that result sets a reserved status bit in the outer group. The outer group's combined result drives a registered output stage. A pin-enable configuration bit controls that stage: when the bit is 1, new values pass through; when it is 0, the last value is held.

Software reaches every register through a simple single-cycle read/write port. Reads are combinational from the address. Status bits are cleared by writing 1 to them. To quiet the pin for a while, software keeps pin-enable at 1, clears all outer status bits, and only then writes pin-enable to 0. The output is then held low no matter what events arrive later.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A high bit on `inner_evt` or `outer_evt` sets the matching status bit at the next clock edge. This happens even when its enable bit is 0. A status bit stays set until it is cleared.
- R2: Writing to a status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R3: When an event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Outer status bit 5 is set one edge after this condition holds: (inner status AND inner enable[5:0]) is nonzero AND inner enable bit 31 is 1. It is not set when the master bit is 0 or when no enabled inner bit is pending.
- R5: Clearing outer status bit 5 has no lasting effect while an enabled inner source is still pending under the master enable. The bit is set again on the following edge.
- R6: When pin-enable is 1, `irq_o` equals the OR of (outer status AND outer enable[5:0]), one clock later.
- R7: When pin-enable is 0, `irq_o` keeps its last value, whether that value is high or low.
- R8: Software can freeze the pin low with this order: keep pin-enable at 1, clear all outer status bits, then write pin-enable to 0. After that, `irq_o` stays 0 while new events arrive, and the status bits still record those events.
- R9: After reset, all status and enable registers, pin-enable and `irq_o` are 0.
- R10: The register map is:

  | Address | Register | Bits that read back |
  |---|---|---|
  | 0 | inner status | [5:0] |
  | 1 | inner enable | [5:0] and master bit 31 |
  | 2 | outer status | [5:0], bit 5 is the cascade bit, bits [4:0] come from `outer_evt` |
  | 3 | outer enable | [5:0] |
  | 4 | configuration | bit 0 = pin-enable |

  All other bits, and all other addresses, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inner_evt | input | 6 | Inner-group event pulses |
| outer_evt | input | 5 | Direct outer-group event pulses, bits [4:0] |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt output, active high, registered |

## Verification
The bench drives inner events under three enable settings: no enable bits, enable bits without the master bit, and both together. This separates raw capture from per-source masking and from master gating. Direct outer events are then steered through the outer enable, and the pin-enable is toggled while the line is high and while it is low. This shows the difference between a transparent stage and a held one. The remaining patterns cover the tie between an event and a clear in the same cycle, a clear of the cascade bit while its inner source is still pending, and the freeze-low order followed by a late event.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int DATA_W  = 32;
  localparam int MST_BIT = 31;

  localparam logic [2:0] A_IN_STAT  = 3'd0;
  localparam logic [2:0] A_IN_EN    = 3'd1;
  localparam logic [2:0] A_OUT_STAT = 3'd2;
  localparam logic [2:0] A_OUT_EN   = 3'd3;
  localparam logic [2:0] A_CFG      = 3'd4;

  // masked OR of a status/enable pair, gated by a master bit
  function automatic logic masked_any(logic [DATA_W-1:0] stat,
                                      logic [DATA_W-1:0] en,
                                      logic              mst);
    return mst & (|(stat & en));
  endfunction
endpackage

// File: rtl/irq_grp.sv
module irq_grp
  import irq_cascade_pkg::*;
#(
  parameter int N       = 6,
  parameter bit HAS_MST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we,
  input  logic [N-1:0] en_wd,
  input  logic         mst_wd,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] en_o,
  output logic         mst_o,
  output logic         hit_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] en_q;
  logic         mst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wd;
  end

  generate
    if (HAS_MST) begin : g_mst
      always_ff @(posedge clk) begin
        if (!rst_n)     mst_q <= 1'b0;
        else if (en_we) mst_q <= mst_wd;
      end
    end else begin : g_nomst
      logic unused_mst;
      assign unused_mst = mst_wd;
      assign mst_q = 1'b1;
    end
  endgenerate

  assign hit_o  = masked_any(DATA_W'(stat_q), DATA_W'(en_q), mst_q);
  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign mst_o  = mst_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));
  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q) |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0));
endmodule

// File: rtl/irq_pin_latch.sv
module irq_pin_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_en,
  input  logic any_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (pin_en) irq_q <= any_i;
  end

  assign irq_o = irq_q;

  // R6
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_en |=> (irq_q == $past(any_i)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=> $stable(irq_q));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int IN_SRC  = 6,
  parameter int OUT_SRC = 6,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IN_SRC-1:0]  inner_evt,
  input  logic [OUT_SRC-2:0] outer_evt,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  localparam int CASC_BIT = OUT_SRC - 1;

  logic [IN_SRC-1:0]  in_stat, in_en, in_clr;
  logic [OUT_SRC-1:0] out_stat, out_en, out_clr, out_set;
  logic               in_mst, out_mst_unused;
  logic               inner_hit, outer_any;
  logic               pin_en_q;
  logic               wr_in_stat, wr_in_en, wr_out_stat, wr_out_en, wr_cfg;

  assign wr_in_stat  = reg_wr && (reg_addr == ADDR_W'(A_IN_STAT));
  assign wr_in_en    = reg_wr && (reg_addr == ADDR_W'(A_IN_EN));
  assign wr_out_stat = reg_wr && (reg_addr == ADDR_W'(A_OUT_STAT));
  assign wr_out_en   = reg_wr && (reg_addr == ADDR_W'(A_OUT_EN));
  assign wr_cfg      = reg_wr && (reg_addr == ADDR_W'(A_CFG));

  assign in_clr  = wr_in_stat  ? reg_wdata[IN_SRC-1:0]  : '0;
  assign out_clr = wr_out_stat ? reg_wdata[OUT_SRC-1:0] : '0;
  assign out_set = {inner_hit, outer_evt};

  irq_grp #(.N(IN_SRC), .HAS_MST(1'b1)) u_inner (
    .clk(clk), .rst_n(rst_n), .set_i(inner_evt), .clr_i(in_clr),
    .en_we(wr_in_en), .en_wd(reg_wdata[IN_SRC-1:0]), .mst_wd(reg_wdata[MST_BIT]),
    .stat_o(in_stat), .en_o(in_en), .mst_o(in_mst), .hit_o(inner_hit)
  );

  irq_grp #(.N(OUT_SRC), .HAS_MST(1'b0)) u_outer (
    .clk(clk), .rst_n(rst_n), .set_i(out_set), .clr_i(out_clr),
    .en_we(wr_out_en), .en_wd(reg_wdata[OUT_SRC-1:0]), .mst_wd(1'b0),
    .stat_o(out_stat), .en_o(out_en), .mst_o(out_mst_unused), .hit_o(outer_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      pin_en_q <= 1'b0;
    else if (wr_cfg) pin_en_q <= reg_wdata[0];
  end

  irq_pin_latch u_pin (
    .clk(clk), .rst_n(rst_n), .pin_en(pin_en_q), .any_i(outer_any), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_IN_STAT):  reg_rdata[IN_SRC-1:0]  = in_stat;
      ADDR_W'(A_IN_EN): begin
        reg_rdata[IN_SRC-1:0] = in_en;
        reg_rdata[MST_BIT]    = in_mst;
      end
      ADDR_W'(A_OUT_STAT): reg_rdata[OUT_SRC-1:0] = out_stat;
      ADDR_W'(A_OUT_EN):   reg_rdata[OUT_SRC-1:0] = out_en;
      ADDR_W'(A_CFG):      reg_rdata[0]           = pin_en_q;
      default:             reg_rdata = '0;
    endcase
  end

  // R4
  cascade_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inner_hit |=> out_stat[CASC_BIT]);
  // R4
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_mst |-> !inner_hit);
  // R9
  rst_irq_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_o);
endmodule

// File: tb/irq_cascade_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  inner_evt = '0;
  logic [4:0]  outer_evt = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .inner_evt(inner_evt), .outer_evt(outer_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // monitor: compares queued expectations just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_irq ? {31'd0, irq_o} : reg_rdata;
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string r);
    @(negedge clk);
    reg_addr = a;
    reg_wr   = 1'b0;
    sb.push_back('{1'b0, e, r});
    @(posedge clk);
    #2;
  endtask

  task automatic chk_irq(input logic e, input string r);
    @(negedge clk);
    sb.push_back('{1'b1, {31'd0, e}, r});
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_in(input logic [5:0] v);
    @(negedge clk); inner_evt = v;
    @(negedge clk); inner_evt = '0;
  endtask

  task automatic pulse_out(input logic [4:0] v);
    @(negedge clk); outer_evt = v;
    @(negedge clk); outer_evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    for (int a = 0; a < 5; a++) chk_rd(3'(a), 32'h0, "R9");
    chk_irq(1'b0, "R9");

    wr(3'd3, 32'h3F);
    wr(3'd4, 32'h1);
    // R1 capture with inner enable 0
    pulse_in(6'h05); idle(3);
    chk_rd(3'd0, 32'h05, "R1");
    chk_rd(3'd2, 32'h00, "R4");
    chk_irq(1'b0, "R4");
    // R4 enables without master
    wr(3'd1, 32'h05); idle(3);
    chk_rd(3'd2, 32'h00, "R4");
    chk_rd(3'd1, 32'h05, "R10");
    // R4 master on
    wr(3'd1, 32'h8000_0005); idle(3);
    chk_rd(3'd2, 32'h20, "R4");
    chk_irq(1'b1, "R6");
    chk_rd(3'd1, 32'h8000_0005, "R10");
    // R5 clear of cascade bit while pending
    wr(3'd2, 32'h20); idle(2);
    chk_rd(3'd2, 32'h20, "R5");
    // R2 writing 0 keeps bits
    wr(3'd0, 32'h0); idle(1);
    chk_rd(3'd0, 32'h05, "R2");
    wr(3'd0, 32'h01); idle(1);
    chk_rd(3'd0, 32'h04, "R2");
    wr(3'd0, 32'h04);
    wr(3'd2, 32'h20); idle(3);
    chk_rd(3'd2, 32'h00, "R2");
    chk_irq(1'b0, "R6");
    // R6 direct outer source and enable masking
    pulse_out(5'h04); idle(2);
    chk_rd(3'd2, 32'h04, "R1");
    chk_irq(1'b1, "R6");
    wr(3'd3, 32'h00); idle(2);
    chk_irq(1'b0, "R6");
    chk_rd(3'd2, 32'h04, "R1");
    wr(3'd3, 32'h3F); idle(2);
    chk_irq(1'b1, "R6");
    // R7 hold high with pin-enable 0
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h3F); idle(3);
    chk_irq(1'b1, "R7");
    chk_rd(3'd4, 32'h0, "R10");
    wr(3'd4, 32'h1); idle(2);
    chk_irq(1'b0, "R6");
    // R8 freeze-low order
    pulse_out(5'h01); idle(2);
    chk_irq(1'b1, "R6");
    wr(3'd2, 32'h3F);
    wr(3'd4, 32'h0);
    pulse_out(5'h02); idle(3);
    chk_irq(1'b0, "R8");
    chk_rd(3'd2, 32'h02, "R8");
    pulse_in(6'h01); idle(3);
    chk_irq(1'b0, "R7");
    chk_rd(3'd2, 32'h22, "R8");
    // R3 set and clear in the same cycle
    wr(3'd0, 32'h3F);
    wr(3'd2, 32'h3F); idle(1);
    @(negedge clk);
    outer_evt = 5'h08; reg_addr = 3'd2; reg_wdata = 32'h08; reg_wr = 1'b1;
    @(negedge clk);
    outer_evt = '0; reg_wr = 1'b0;
    chk_rd(3'd2, 32'h08, "R3");
    // R10 unused bits and addresses
    wr(3'd3, 32'hFFFF_FFFF);
    chk_rd(3'd3, 32'h3F, "R10");
    wr(3'd4, 32'hFFFF_FFFF);
    chk_rd(3'd4, 32'h1, "R10");
    chk_rd(3'd6, 32'h0, "R10");
    idle(2);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule